// File: doc/BRIEF.md
# Associative Page Frame Translator

This block models the translation stage of a demand-paged primary store with a fixed set of page frames. Every frame owns one register that holds the virtual page number currently resident in it, plus a valid flag. A lookup presents a virtual page number and a word offset. The page number is compared against every frame register at once. On a hit, the block returns the frame index, and the physical address formed by placing the frame index above the word offset, in the same cycle.

On a miss the block raises a fault and always offers a victim frame for the handler to fill. If any frame is empty, the lowest-numbered empty frame is offered. Otherwise the least recently used frame is offered. Recency is kept as a rank per frame. A hit lookup or an install moves that frame to most recent.

A fault handler fills the offered frame with the install port. It can also empty any frame with the drop port. Moving data between the backing store and the frames is outside this block.

Top module: `frame_cam_xlate`

## Requirements
- R1: After reset every frame is empty: any lookup gives fault=1 and hit=0, victim_frame=0 and victim_free=1.
- R2: With look_en=1 and a valid frame whose page equals look_page, hit=1 and fault=0 in the same cycle. hit_frame is that frame's index and phys_addr={hit_frame, look_off}, with the offset in bits [8:0] and the frame in bits [13:9].
- R3: With look_en=1 and no valid matching frame, fault=1, hit=0, hit_frame=0 and phys_addr=0. With look_en=0, hit=0 and fault=0.
- R4: While any frame is empty, victim_free=1 and victim_frame is the lowest-numbered empty frame.
- R5: While all frames are valid, victim_free=0 and victim_frame is the least recently used frame (oldest rank, ties to the lowest index).
- R6: A hit lookup or an install makes that frame the most recent from the next cycle. If both happen in one cycle, only the installed frame is moved; the hit frame keeps its rank.
- R7: inst_en=1 writes inst_page into frame inst_frame and marks it valid. A lookup of that page hits that frame from the next cycle.
- R8: drop_en=1 marks frame drop_frame empty from the next cycle. An install to the same frame in the same cycle wins, and the frame ends valid with the new page.
- R9: An empty frame never hits, even when its stored page equals look_page.
- R10: At most one valid frame ever matches a lookup. With distinct pages installed, each page is reported by its own frame alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| look_en | input | 1 | Lookup request |
| look_page | input | 11 | Virtual page number to translate |
| look_off | input | 9 | Word offset within the page |
| inst_en | input | 1 | Install a page into a frame |
| inst_frame | input | 5 | Frame to install into |
| inst_page | input | 11 | Page number to install |
| drop_en | input | 1 | Empty a frame |
| drop_frame | input | 5 | Frame to empty |
| hit | output | 1 | Lookup found a resident page |
| fault | output | 1 | Lookup found no resident page |
| hit_frame | output | 5 | Frame holding the page on a hit, else 0 |
| phys_addr | output | 14 | Frame index above the offset on a hit, else 0 |
| victim_frame | output | 5 | Frame proposed for the next install |
| victim_free | output | 1 | Proposed frame is empty |

## Verification
The bench fills all frames and then walks the recency order through hits, misses, drops and installs. A design that updated rank on a miss, or lost the order across a drop, would offer the wrong victim. It drops a frame whose stored page is still present and looks that page up; a design that ignored the valid flag would report a stale hit. It drives an install and a drop to one frame in the same cycle, and a hit and an install in the same cycle. A wrong priority would leave the frame empty, or move the hit frame and change the next victim. It also checks phys_addr at offsets 0, 511 and between, which catches a frame/offset packing that is swapped or truncated.

// File: rtl/fcx_pkg.sv
package fcx_pkg;
   localparam int unsigned FCX_FRAMES = 32;
   localparam int unsigned FCX_PAGE_W = 11;
   localparam int unsigned FCX_OFF_W  = 9;

   function automatic int unsigned fcx_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/fcx_match.sv
module fcx_match #(
   parameter int unsigned NF     = 32,
   parameter int unsigned PAGE_W = 11,
   parameter int unsigned IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [NF-1:0]     valid_vec,
   input  logic [PAGE_W-1:0] page_arr [NF],
   input  logic [PAGE_W-1:0] key,
   output logic              any_match,
   output logic [IDX_W-1:0]  match_idx
);
   logic [NF-1:0] match_vec;

   for (genvar f = 0; f < NF; f++) begin : g_cmp
      assign match_vec[f] = valid_vec[f] && (page_arr[f] == key);
   end

   assign any_match = |match_vec;

   always_comb begin
      match_idx = '0;
      for (int i = NF - 1; i >= 0; i--) begin
         if (match_vec[i]) match_idx = IDX_W'(i);
      end
   end

   // R10
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot0(match_vec));
endmodule

// File: rtl/fcx_age.sv
module fcx_age #(
   parameter int unsigned NF    = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] oldest_idx
);
   logic [IDX_W-1:0] age_q [NF];
   logic [IDX_W-1:0] touch_age;
   logic [NF-1:0]    oldest_vec;

   assign touch_age = age_q[touch_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) age_q[i] <= IDX_W'(i);
      end else if (touch) begin
         for (int i = 0; i < NF; i++) begin
            if (touch_idx == IDX_W'(i))    age_q[i] <= '0;
            else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   for (genvar f = 0; f < NF; f++) begin : g_old
      assign oldest_vec[f] = (age_q[f] == IDX_W'(NF - 1));
   end

   always_comb begin
      logic [IDX_W-1:0] best_age;
      oldest_idx = '0;
      best_age   = age_q[0];
      for (int i = 1; i < NF; i++) begin
         if (age_q[i] > best_age) begin
            best_age   = age_q[i];
            oldest_idx = IDX_W'(i);
         end
      end
   end

   // R6
   touch_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> (age_q[$past(touch_idx)] == '0));
   // R5
   one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);
endmodule

// File: rtl/fcx_victim.sv
module fcx_victim #(
   parameter int unsigned NF    = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic [NF-1:0]    valid_vec,
   input  logic [IDX_W-1:0] lru_idx,
   output logic [IDX_W-1:0] victim_idx,
   output logic             victim_free
);
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      free_idx = '0;
      for (int i = NF - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   assign victim_free = ~&valid_vec;
   assign victim_idx  = victim_free ? free_idx : lru_idx;
endmodule

// File: rtl/frame_cam_xlate.sv
module frame_cam_xlate #(
   parameter int unsigned NUM_FRAMES = fcx_pkg::FCX_FRAMES,
   parameter int unsigned PAGE_W     = fcx_pkg::FCX_PAGE_W,
   parameter int unsigned OFF_W      = fcx_pkg::FCX_OFF_W,
   localparam int unsigned IDX_W     = fcx_pkg::fcx_idx_w(NUM_FRAMES),
   localparam int unsigned PA_W      = IDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              look_en,
   input  logic [PAGE_W-1:0] look_page,
   input  logic [OFF_W-1:0]  look_off,
   input  logic              inst_en,
   input  logic [IDX_W-1:0]  inst_frame,
   input  logic [PAGE_W-1:0] inst_page,
   input  logic              drop_en,
   input  logic [IDX_W-1:0]  drop_frame,
   output logic              hit,
   output logic              fault,
   output logic [IDX_W-1:0]  hit_frame,
   output logic [PA_W-1:0]   phys_addr,
   output logic [IDX_W-1:0]  victim_frame,
   output logic              victim_free
);
   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("frame_cam_xlate: NUM_FRAMES must be at least 2");
   end
   if (PAGE_W < 1 || OFF_W < 1) begin : g_bad_widths
      $error("frame_cam_xlate: PAGE_W and OFF_W must be at least 1");
   end

   logic [NUM_FRAMES-1:0] vld_q;
   logic [PAGE_W-1:0]     page_q [NUM_FRAMES];
   logic                  any_match;
   logic [IDX_W-1:0]      match_idx;
   logic                  touch;
   logic [IDX_W-1:0]      touch_idx;
   logic [IDX_W-1:0]      lru_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < NUM_FRAMES; i++) page_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_FRAMES; i++) begin
            if (inst_en && inst_frame == IDX_W'(i)) begin
               vld_q[i]  <= 1'b1;
               page_q[i] <= inst_page;
            end else if (drop_en && drop_frame == IDX_W'(i)) begin
               vld_q[i]  <= 1'b0;
            end
         end
      end
   end

   fcx_match #(.NF(NUM_FRAMES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) i_match (
      .clk(clk), .rst_n(rst_n), .en(look_en), .valid_vec(vld_q),
      .page_arr(page_q), .key(look_page),
      .any_match(any_match), .match_idx(match_idx)
   );

   assign hit       = look_en && any_match;
   assign fault     = look_en && !any_match;
   assign hit_frame = hit ? match_idx : '0;
   assign phys_addr = hit ? {match_idx, look_off} : '0;

   assign touch     = inst_en || hit;
   assign touch_idx = inst_en ? inst_frame : match_idx;

   fcx_age #(.NF(NUM_FRAMES), .IDX_W(IDX_W)) i_age (
      .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
      .oldest_idx(lru_idx)
   );

   fcx_victim #(.NF(NUM_FRAMES), .IDX_W(IDX_W)) i_victim (
      .valid_vec(vld_q), .lru_idx(lru_idx),
      .victim_idx(victim_frame), .victim_free(victim_free)
   );

   // R7
   load_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inst_en |=> (vld_q[$past(inst_frame)] && page_q[$past(inst_frame)] == $past(inst_page)));
   // R8
   inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_en && !(inst_en && inst_frame == drop_frame)) |=> !vld_q[$past(drop_frame)]);
   // R4
   free_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      victim_free |-> !vld_q[victim_frame]);
   // R5
   lru_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !inst_en && !drop_en && (&vld_q)) |=> (victim_frame != $past(hit_frame)));
endmodule

// File: tb/test_frame_cam_xlate.sv
module test_frame_cam_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        look_en = 1'b0;
   logic [10:0] look_page = '0;
   logic [8:0]  look_off = '0;
   logic        inst_en = 1'b0;
   logic [4:0]  inst_frame = '0;
   logic [10:0] inst_page = '0;
   logic        drop_en = 1'b0;
   logic [4:0]  drop_frame = '0;
   logic        hit, fault, victim_free;
   logic [4:0]  hit_frame, victim_frame;
   logic [13:0] phys_addr;

   int n_cmp = 0;
   int n_bad = 0;

   logic        s_hit, s_fault, s_vfree;
   logic [4:0]  s_frame, s_vic;
   logic [13:0] s_phys;

   frame_cam_xlate i_frame_cam_xlate (
      .clk(clk), .rst_n(rst_n), .look_en(look_en), .look_page(look_page),
      .look_off(look_off), .inst_en(inst_en), .inst_frame(inst_frame),
      .inst_page(inst_page), .drop_en(drop_en), .drop_frame(drop_frame),
      .hit(hit), .fault(fault), .hit_frame(hit_frame), .phys_addr(phys_addr),
      .victim_frame(victim_frame), .victim_free(victim_free)
   );

   always #5 clk = ~clk;

   // op: 0 idle, 1 lookup, 2 install, 3 drop
   typedef struct packed {
      logic [1:0]  op;
      logic [4:0]  frame;
      logic [10:0] page;
      logic [8:0]  off;
      logic        ehit;
      logic [4:0]  eframe;
      logic [4:0]  evic;
      logic        evfree;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 5'd0,  11'd100, 9'd5,   1'b1, 5'd0,  5'd1, 1'b0},
      '{2'd1, 5'd0,  11'd101, 9'd511, 1'b1, 5'd1,  5'd2, 1'b0},
      '{2'd1, 5'd0,  11'd999, 9'd0,   1'b0, 5'd0,  5'd2, 1'b0},
      '{2'd1, 5'd0,  11'd102, 9'd77,  1'b1, 5'd2,  5'd3, 1'b0},
      '{2'd3, 5'd7,  11'd0,   9'd0,   1'b0, 5'd0,  5'd7, 1'b1},
      '{2'd1, 5'd0,  11'd107, 9'd0,   1'b0, 5'd0,  5'd7, 1'b1},
      '{2'd3, 5'd4,  11'd0,   9'd0,   1'b0, 5'd0,  5'd4, 1'b1},
      '{2'd2, 5'd4,  11'd500, 9'd0,   1'b0, 5'd0,  5'd7, 1'b1},
      '{2'd1, 5'd0,  11'd500, 9'd3,   1'b1, 5'd4,  5'd7, 1'b1},
      '{2'd2, 5'd7,  11'd501, 9'd0,   1'b0, 5'd0,  5'd3, 1'b0},
      '{2'd1, 5'd0,  11'd103, 9'd1,   1'b1, 5'd3,  5'd5, 1'b0},
      '{2'd1, 5'd0,  11'd131, 9'd2,   1'b1, 5'd31, 5'd5, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic lv, input logic [10:0] lp, input logic [8:0] lo,
                       input logic iv, input logic [4:0] ifr, input logic [10:0] ip,
                       input logic dv, input logic [4:0] dfr);
      @(negedge clk);
      look_en = lv; look_page = lp; look_off = lo;
      inst_en = iv; inst_frame = ifr; inst_page = ip;
      drop_en = dv; drop_frame = dfr;
      #2;
      s_hit = hit; s_fault = fault; s_frame = hit_frame; s_phys = phys_addr;
      @(posedge clk);
      #2;
      s_vic = victim_frame; s_vfree = victim_free;
      look_en = 1'b0; inst_en = 1'b0; drop_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(1'b1, 11'd100, 9'd0, 1'b0, 5'd0, 11'd0, 1'b0, 5'd0);
      chk("R1 fault", 32'(s_fault), 32'd1);
      chk("R1 hit", 32'(s_hit), 32'd0);
      chk("R1 victim", 32'(s_vic), 32'd0);
      chk("R1 victim_free", 32'(s_vfree), 32'd1);

      // R7 install every frame; R4 lowest empty frame offered
      for (int i = 0; i < 32; i++) begin
         step(1'b0, 11'd0, 9'd0, 1'b1, 5'(i), 11'(100 + i), 1'b0, 5'd0);
         if (i == 0 || i == 15 || i == 30) begin
            chk("R4 victim", 32'(s_vic), 32'(i + 1));
            chk("R4 victim_free", 32'(s_vfree), 32'd1);
         end
      end
      chk("R5 victim after fill", 32'(s_vic), 32'd0);
      chk("R5 victim_free after fill", 32'(s_vfree), 32'd0);

      // R10: each distinct page reported by its own frame alone
      for (int i = 0; i < 32; i++) begin
         step(1'b1, 11'(100 + i), 9'd0, 1'b0, 5'd0, 11'd0, 1'b0, 5'd0);
         chk("R10 hit", 32'(s_hit), 32'd1);
         chk("R10 frame", 32'(s_frame), 32'(i));
      end

      // vector table: R2 R3 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         vec_t e;
         e = VECS[v];
         step(e.op == 2'd1, e.page, e.off, e.op == 2'd2, e.frame, e.page,
              e.op == 2'd3, e.frame);
         chk(e.ehit ? "R2 hit" : "R3 hit", 32'(s_hit), 32'(e.ehit));
         chk(e.ehit ? "R2 fault" : "R3 fault", 32'(s_fault),
             32'(e.op == 2'd1 && !e.ehit));
         chk(e.ehit ? "R2 frame" : "R3 frame", 32'(s_frame), 32'(e.eframe));
         chk(e.ehit ? "R2 phys" : "R3 phys", 32'(s_phys),
             e.ehit ? 32'(e.eframe) * 512 + 32'(e.off) : 32'd0);
         chk(e.evfree ? "R4 victim" : "R5 victim", 32'(s_vic), 32'(e.evic));
         chk(e.evfree ? "R4 victim_free" : "R5 victim_free", 32'(s_vfree), 32'(e.evfree));
      end

      // R8: install and drop to one frame in one cycle, install wins
      step(1'b0, 11'd0, 9'd0, 1'b1, 5'd5, 11'd600, 1'b1, 5'd5);
      chk("R6 victim after install", 32'(s_vic), 32'd6);
      chk("R8 victim_free", 32'(s_vfree), 32'd0);
      step(1'b1, 11'd600, 9'd9, 1'b0, 5'd0, 11'd0, 1'b0, 5'd0);
      chk("R8 hit", 32'(s_hit), 32'd1);
      chk("R8 frame", 32'(s_frame), 32'd5);

      // R6: hit and install in one cycle, only the installed frame moves
      step(1'b1, 11'd106, 9'd0, 1'b1, 5'd8, 11'd601, 1'b0, 5'd0);
      chk("R6 hit same cycle", 32'(s_hit), 32'd1);
      chk("R6 frame same cycle", 32'(s_frame), 32'd6);
      chk("R6 victim keeps hit frame", 32'(s_vic), 32'd6);
      step(1'b1, 11'd601, 9'd0, 1'b0, 5'd0, 11'd0, 1'b0, 5'd0);
      chk("R7 hit", 32'(s_hit), 32'd1);
      chk("R7 frame", 32'(s_frame), 32'd8);

      // R9: dropped frame keeps stale page but never hits
      step(1'b0, 11'd0, 9'd0, 1'b0, 5'd0, 11'd0, 1'b1, 5'd9);
      step(1'b1, 11'd109, 9'd0, 1'b0, 5'd0, 11'd0, 1'b0, 5'd0);
      chk("R9 fault", 32'(s_fault), 32'd1);
      chk("R9 hit", 32'(s_hit), 32'd0);
      chk("R4 victim dropped", 32'(s_vic), 32'd9);

      // R1: reset mid-run empties every frame
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 11'd101, 9'd0, 1'b0, 5'd0, 11'd0, 1'b0, 5'd0);
      chk("R1 fault after reset", 32'(s_fault), 32'd1);
      chk("R1 victim after reset", 32'(s_vic), 32'd0);
      chk("R1 victim_free after reset", 32'(s_vfree), 32'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule